// File: doc/BRIEF.md
# Memory-Mapped Character Terminal Controller

This block is a bus slave that connects a processor to a character terminal. It exposes four word registers in a 16-byte window: a control word and a data word for the keyboard side, and a control word and a data word for the display side. Keyboard characters arrive on a valid/ready byte stream. The controller holds one character and flags it as waiting. When the processor reads the character, the flag drops. Display characters are written by the processor. The controller presents each one on an outgoing valid/ready byte stream and flags when it can take the next one.

Software can poll the flag bits. It can also enable a level interrupt for either direction, which stays high for as long as an enabled flag is set. Each direction buffers exactly one byte. A keyboard byte that arrives while the previous one is unread is held back on the stream and never overwritten.

Top module: `term_mmio_ctrl`

## Requirements
- R1: The registers are decoded at word-aligned addresses relative to `BASE_ADDR` (default 0xFFFF0000): +0x0 keyboard control, +0x4 keyboard data, +0x8 display control, +0xC display data. A read of any other address returns zero.
- R2: A control word reads as bit 0 = flag (ready), bit 1 = interrupt enable, and bits 31:2 = zero.
- R3: A write to a control word loads bit 1 of the write data into that direction's enable. Writes to the flag bit and to the upper bits have no effect.
- R4: When the keyboard slot is empty, a byte offered with `kb_valid` is taken at the clock edge. The keyboard flag then reads 1, and the keyboard data word reads the byte in bits 7:0 with bits 31:8 zero.
- R5: A read of the keyboard data word clears the keyboard flag at that clock edge, and `kb_ready` is high in the following cycle.
- R6: While the keyboard flag is 1, `kb_ready` is low. A byte held on the stream is taken only after the waiting one has been read, so neither byte is lost.
- R7: A write to the display data word while the display flag is 1 drives bits 7:0 of the write data onto `dsp_data` with `dsp_valid` high from the next cycle. The display flag reads 0 from that cycle on.
- R8: A write to the display data word while the display flag is 0 is ignored: `dsp_data` keeps the pending byte.
- R9: `dsp_valid` drops in the cycle after the display side accepts the byte. The display flag returns to 1 one cycle after that.
- R10: `irq` is high exactly when (keyboard flag AND keyboard enable) OR (display flag AND display enable) holds.
- R11: After reset the keyboard flag is 0, the display flag is 1, both enables are 0, `irq` is 0 and `dsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the access |
| kb_valid | input | 1 | Keyboard byte offered |
| kb_data | input | 8 | Keyboard byte |
| kb_ready | output | 1 | Controller can take a keyboard byte |
| dsp_valid | output | 1 | Display byte offered |
| dsp_data | output | 8 | Display byte |
| dsp_ready | input | 1 | Display side takes the byte |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest case to reach from the ports is a second keyboard byte that arrives while the first is still unread. The bench holds `kb_valid` high with a new byte while the slot is full and confirms that `kb_ready` stays low. It then reads the data word and watches the held byte enter one edge later without loss. A second hard case is the gap cycle between display acceptance and the return of the flag. The bench releases `dsp_ready` for exactly one edge and reads the display control word in the following cycle, where the flag must still be 0.

// File: rtl/term_mmio_pkg.sv
package term_mmio_pkg;

    localparam int BUS_W  = 32;
    localparam int CHAR_W = 8;
    localparam int WIN_W  = 4;   // address bits spanned by the register window

    typedef enum logic [2:0] {
        REG_NONE,
        REG_KB_CTRL,
        REG_KB_DATA,
        REG_DSP_CTRL,
        REG_DSP_DATA
    } reg_sel_e;

    typedef enum logic [1:0] {
        TXS_IDLE,
        TXS_SEND,
        TXS_DRAIN
    } tx_state_e;

    typedef struct packed {
        logic ie;
        logic ready;
    } ctrl_bits_t;

    function automatic logic [BUS_W-1:0] pack_ctrl(input ctrl_bits_t c);
        return {{(BUS_W-2){1'b0}}, c.ie, c.ready};
    endfunction

    function automatic logic [BUS_W-1:0] widen_char(input logic [CHAR_W-1:0] ch);
        return {{(BUS_W-CHAR_W){1'b0}}, ch};
    endfunction

endpackage

// File: rtl/term_addr_dec.sv
module term_addr_dec
    import term_mmio_pkg::*;
#(
    parameter logic [BUS_W-1:0] BASE_ADDR = 32'hFFFF_0000
) (
    input  logic [BUS_W-1:0] addr,
    output reg_sel_e         sel
);
    localparam int IDX_LO = 2;

    logic in_window;
    assign in_window = (addr[BUS_W-1:WIN_W] == BASE_ADDR[BUS_W-1:WIN_W])
                    && (addr[IDX_LO-1:0] == '0);

    always_comb begin
        sel = REG_NONE;
        if (in_window) begin
            case (addr[WIN_W-1:IDX_LO])
                2'd0:    sel = REG_KB_CTRL;
                2'd1:    sel = REG_KB_DATA;
                2'd2:    sel = REG_DSP_CTRL;
                default: sel = REG_DSP_DATA;
            endcase
        end
    end
endmodule

// File: rtl/term_rx_slot.sv
module term_rx_slot
    import term_mmio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              kb_valid,
    input  logic [CHAR_W-1:0] kb_data,
    output logic              kb_ready,
    input  logic              take,
    input  logic              ie_wr,
    input  logic              ie_val,
    output ctrl_bits_t        ctrl,
    output logic [CHAR_W-1:0] held
);
    logic full_q;
    logic ie_q;
    logic [CHAR_W-1:0] byte_q;

    assign kb_ready = !full_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            ie_q   <= 1'b0;
            byte_q <= '0;
        end else begin
            if (ie_wr) ie_q <= ie_val;
            if (kb_valid && !full_q) begin
                full_q <= 1'b1;
                byte_q <= kb_data;
            end else if (take) begin
                full_q <= 1'b0;
            end
        end
    end

    assign ctrl.ready = full_q;
    assign ctrl.ie    = ie_q;
    assign held       = byte_q;
endmodule

// File: rtl/term_tx_slot.sv
module term_tx_slot
    import term_mmio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [CHAR_W-1:0] load_char,
    input  logic              ie_wr,
    input  logic              ie_val,
    output logic              dsp_valid,
    output logic [CHAR_W-1:0] dsp_data,
    input  logic              dsp_ready,
    output ctrl_bits_t        ctrl
);
    tx_state_e state_q;
    logic ie_q;
    logic [CHAR_W-1:0] byte_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TXS_IDLE;
            ie_q    <= 1'b0;
            byte_q  <= '0;
        end else begin
            if (ie_wr) ie_q <= ie_val;
            case (state_q)
                TXS_IDLE: if (load) begin
                    byte_q  <= load_char;
                    state_q <= TXS_SEND;
                end
                TXS_SEND: if (dsp_ready) state_q <= TXS_DRAIN;
                default:  state_q <= TXS_IDLE;
            endcase
        end
    end

    assign dsp_valid  = (state_q == TXS_SEND);
    assign dsp_data   = byte_q;
    assign ctrl.ready = (state_q == TXS_IDLE);
    assign ctrl.ie    = ie_q;
endmodule

// File: rtl/term_mmio_ctrl.sv
module term_mmio_ctrl
    import term_mmio_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR = 32'hFFFF_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_sel,
    input  logic        bus_we,
    input  logic [31:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        kb_valid,
    input  logic [7:0]  kb_data,
    output logic        kb_ready,
    output logic        dsp_valid,
    output logic [7:0]  dsp_data,
    input  logic        dsp_ready,
    output logic        irq
);
    localparam int IE_BIT = 1;

    reg_sel_e          sel;
    ctrl_bits_t        kb_ctrl;
    ctrl_bits_t        dsp_ctrl;
    logic [CHAR_W-1:0] kb_held;
    logic              rd, wr;

    assign rd = bus_sel && !bus_we;
    assign wr = bus_sel &&  bus_we;

    term_addr_dec #(.BASE_ADDR(BASE_ADDR)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    term_rx_slot u_rx (
        .clk      (clk),
        .rst      (rst),
        .kb_valid (kb_valid),
        .kb_data  (kb_data),
        .kb_ready (kb_ready),
        .take     (rd && sel == REG_KB_DATA),
        .ie_wr    (wr && sel == REG_KB_CTRL),
        .ie_val   (bus_wdata[IE_BIT]),
        .ctrl     (kb_ctrl),
        .held     (kb_held)
    );

    term_tx_slot u_tx (
        .clk       (clk),
        .rst       (rst),
        .load      (wr && sel == REG_DSP_DATA),
        .load_char (bus_wdata[CHAR_W-1:0]),
        .ie_wr     (wr && sel == REG_DSP_CTRL),
        .ie_val    (bus_wdata[IE_BIT]),
        .dsp_valid (dsp_valid),
        .dsp_data  (dsp_data),
        .dsp_ready (dsp_ready),
        .ctrl      (dsp_ctrl)
    );

    always_comb begin
        case (sel)
            REG_KB_CTRL:  bus_rdata = pack_ctrl(kb_ctrl);
            REG_KB_DATA:  bus_rdata = widen_char(kb_held);
            REG_DSP_CTRL: bus_rdata = pack_ctrl(dsp_ctrl);
            default:      bus_rdata = '0;
        endcase
    end

    assign irq = (kb_ctrl.ready & kb_ctrl.ie) | (dsp_ctrl.ready & dsp_ctrl.ie);
endmodule

// File: rtl/term_mmio_chk.sv
module term_mmio_chk #(
    parameter logic [31:0] BASE_ADDR = 32'hFFFF_0000
) (
    input logic        clk,
    input logic        rst,
    input logic        bus_sel,
    input logic        bus_we,
    input logic [31:0] bus_addr,
    input logic [31:0] bus_rdata,
    input logic        kb_valid,
    input logic        kb_ready,
    input logic        dsp_valid,
    input logic [7:0]  dsp_data,
    input logic        dsp_ready,
    input logic        irq
);
    logic rd_any, in_win, rd_ctrl, rd_kbdata;
    assign rd_any    = bus_sel && !bus_we;
    assign in_win    = (bus_addr[31:4] == BASE_ADDR[31:4]) && (bus_addr[1:0] == 2'b00);
    assign rd_ctrl   = rd_any && in_win && (bus_addr[2] == 1'b0);
    assign rd_kbdata = rd_any && in_win && (bus_addr[3:2] == 2'd1);

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_any && !in_win) |-> (bus_rdata == 32'd0));                    // R1
    AST_CTRL_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd_ctrl |-> (bus_rdata[31:2] == 30'd0));                          // R2
    AST_KB_TAKEN_STALLS: assert property (@(posedge clk) disable iff (rst)
        (kb_valid && kb_ready) |=> !kb_ready);                            // R6
    AST_KB_READ_FREES: assert property (@(posedge clk) disable iff (rst)
        (rd_kbdata && !kb_valid) |=> kb_ready);                           // R5
    AST_DSP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (dsp_valid && !dsp_ready) |=> (dsp_valid && $stable(dsp_data)));  // R8
    AST_DSP_DROPS: assert property (@(posedge clk) disable iff (rst)
        (dsp_valid && dsp_ready) |=> !dsp_valid);                         // R9
    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
        irq |-> (!kb_ready || !dsp_valid));                               // R10
endmodule

bind term_mmio_ctrl term_mmio_chk #(.BASE_ADDR(BASE_ADDR)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .kb_valid  (kb_valid),
    .kb_ready  (kb_ready),
    .dsp_valid (dsp_valid),
    .dsp_data  (dsp_data),
    .dsp_ready (dsp_ready),
    .irq       (irq)
);

// File: tb/tb_term_mmio_ctrl.sv
module tb_term_mmio_ctrl;
    localparam logic [31:0] BASE = 32'hFFFF_0000;
    localparam int NVEC = 8;
    // entry: {write, offset[7:0], wdata[31:0], expected read[31:0]}
    localparam logic [72:0] VEC [NVEC] = '{
        {1'b1, 8'h00, 32'hFFFF_FFFF, 32'h0},  // R3 set kb enable, ready bit ignored
        {1'b0, 8'h00, 32'h0,         32'h2},  // R2 R3
        {1'b1, 8'h08, 32'hFFFF_FFFE, 32'h0},  // R3 set dsp enable
        {1'b0, 8'h08, 32'h0,         32'h3},  // R2
        {1'b1, 8'h08, 32'h0,         32'h0},  // R3 clear dsp enable, flag stays
        {1'b0, 8'h08, 32'h0,         32'h1},  // R3
        {1'b0, 8'h10, 32'h0,         32'h0},  // R1 past window
        {1'b0, 8'h04, 32'h0,         32'h0}   // R4 empty slot data
    };

    logic        clk = 0, rst = 1;
    logic        bus_sel = 0, bus_we = 0;
    logic [31:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
    logic        kb_valid = 0, kb_ready;
    logic [7:0]  kb_data = 0, dsp_data;
    logic        dsp_valid, dsp_ready = 0, irq;
    int          n_chk = 0, n_fail = 0;
    logic        done = 0;
    logic [31:0] rv;

    always #4 clk = ~clk;

    term_mmio_ctrl #(.BASE_ADDR(BASE)) dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .kb_valid(kb_valid), .kb_data(kb_data), .kb_ready(kb_ready),
        .dsp_valid(dsp_valid), .dsp_data(dsp_data), .dsp_ready(dsp_ready),
        .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // caller is at a falling edge; task returns at the next falling edge
    task automatic bus_wr(input logic [31:0] a, input logic [31:0] d);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic bus_rd(input logic [31:0] a, output logic [31:0] d);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_sel = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R11 reset state
        chk("R11 irq", {31'd0, irq}, 32'd0);
        chk("R11 dsp_valid", {31'd0, dsp_valid}, 32'd0);
        chk("R11 kb_ready", {31'd0, kb_ready}, 32'd1);
        bus_rd(BASE + 32'h0, rv); chk("R11 kb ctrl", rv, 32'h0);
        bus_rd(BASE + 32'h8, rv); chk("R11 dsp ctrl", rv, 32'h1);

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][72]) bus_wr(BASE + {24'd0, VEC[i][71:64]}, VEC[i][63:32]);
            else begin
                bus_rd(BASE + {24'd0, VEC[i][71:64]}, rv);
                chk("R1/R2/R3 table", rv, VEC[i][31:0]);
            end
        end
        bus_rd(32'h0000_0004, rv); chk("R1 outside window", rv, 32'h0);
        bus_rd(BASE + 32'h2, rv);  chk("R1 misaligned", rv, 32'h0);
        chk("R10 idle irq", {31'd0, irq}, 32'd0);

        // keyboard path: kb enable=1, dsp enable=0
        kb_valid = 1; kb_data = 8'h5A;
        @(posedge clk); @(negedge clk);
        kb_valid = 0;
        chk("R6 kb_ready low when full", {31'd0, kb_ready}, 32'd0);
        chk("R10 kb irq", {31'd0, irq}, 32'd1);
        bus_rd(BASE + 32'h0, rv); chk("R4 kb flag set", rv, 32'h3);
        kb_valid = 1; kb_data = 8'hA5;
        repeat (3) @(negedge clk);
        chk("R6 held off", {31'd0, kb_ready}, 32'd0);
        bus_rd(BASE + 32'h4, rv); chk("R6 first byte kept", rv, 32'h5A);
        chk("R5 kb_ready after read", {31'd0, kb_ready}, 32'd1);
        @(posedge clk); @(negedge clk);
        kb_valid = 0;
        bus_rd(BASE + 32'h4, rv); chk("R4 second byte", rv, 32'hA5);
        bus_rd(BASE + 32'h0, rv); chk("R5 flag cleared", rv, 32'h2);
        chk("R10 irq drops", {31'd0, irq}, 32'd0);

        // display path
        bus_wr(BASE + 32'hC, 32'h1234_56C3);
        chk("R7 dsp_valid", {31'd0, dsp_valid}, 32'd1);
        chk("R7 dsp_data", {24'd0, dsp_data}, 32'hC3);
        bus_rd(BASE + 32'h8, rv); chk("R7 flag low", rv, 32'h0);
        bus_wr(BASE + 32'hC, 32'h0000_0077);
        chk("R8 byte kept", {24'd0, dsp_data}, 32'hC3);
        chk("R8 still valid", {31'd0, dsp_valid}, 32'd1);
        dsp_ready = 1;
        @(posedge clk); @(negedge clk);
        dsp_ready = 0;
        chk("R9 valid drops", {31'd0, dsp_valid}, 32'd0);
        bus_rd(BASE + 32'h8, rv); chk("R9 gap cycle", rv, 32'h0);
        bus_rd(BASE + 32'h8, rv); chk("R9 flag back", rv, 32'h1);
        chk("R9 no resend", {31'd0, dsp_valid}, 32'd0);
        bus_wr(BASE + 32'h8, 32'h2);
        chk("R10 dsp irq", {31'd0, irq}, 32'd1);
        bus_wr(BASE + 32'h8, 32'h0);
        chk("R10 dsp irq off", {31'd0, irq}, 32'd0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule